// File: doc/BRIEF.md
# Receiver error flag with hold timer

This block decides when a biphase-mark audio receiver reports an error. It watches the lock indication, missing-preamble strobes, the parity of each subframe, the non-PCM indication, the sampling-rate bits of the channel status carried once per block, and a measured sample-rate code. From these it drives one error flag and one mute control for the audio data path. Serious faults are treated as lock-style errors. A lock-style error keeps the flag high for a minimum number of frames and mutes the data. Isolated parity errors can be shown as a short soft flag, or they can be hidden.

Every change of the flag is aligned to a rising edge of the left/right frame clock. A hold state machine makes the lock-style decision. It has four states:
- ST_IDLE: no lock-style error.
- ST_ARMED: a cause has been seen and the machine is waiting for a frame edge.
- ST_FAULT: the flag is high and a cause is still present.
- ST_HOLD: the flag is high, no cause is present, and frame edges are being counted.

The transitions are:
- ST_IDLE goes to ST_ARMED when any cause appears.
- ST_ARMED goes to ST_FAULT on the next frame edge.
- ST_FAULT goes to ST_HOLD in the first cycle with no cause.
- ST_HOLD goes back to ST_FAULT when a cause returns.
- ST_HOLD goes to ST_IDLE on the frame edge that completes `HOLD_FRAMES` quiet frames.

The default of 4800 frames is 100 ms at 48 kHz.

Top module: `rx_err_flag`

## Requirements
- R1: When `lock_i` is low, or `pre_miss_i` pulses, a lock-style error starts. `err_o` and `mute_o` go high together at the first rising frame-clock edge that follows.
- R2: After a lock-style error, `err_o` and `mute_o` fall only after `HOLD_FRAMES` rising frame-clock edges during which no cause was present. Any cause during that count restarts it.
- R3: A rising frame-clock edge is the first clock in which `lrck_i` is sampled high after it was sampled low. `err_o` changes only in the clock that follows such a sample.
- R4: A parity error is a cycle with `sf_stb_i`=1 and `sf_odd_i`=1, where `sf_odd_i`=1 means the subframe's parity bits hold an odd number of ones. The run counter of consecutive parity errors clears on a subframe with `sf_odd_i`=0. It saturates at 2^`RUN_W`-1 and does not wrap.
- R5: A run of `PAR_LIMIT` (9) or more consecutive parity errors is a lock-style error, and the cause lasts until the next good subframe. With `cfg_soft_fmt_i`=0, shorter runs leave `err_o` and `mute_o` low.
- R6: With `cfg_soft_fmt_i`=1, a frame that contains a parity error raises `err_o` for the frame period that follows, and `mute_o` stays low. With `cfg_soft_fmt_i`=0, no soft flag is produced.
- R7: On a `blk_stb_i` cycle, a value of `cs_fs_i` (channel-status bits 24 to 27) that differs from the previous block's value is a lock-style error.
- R8: On a `blk_stb_i` cycle, a value of `meas_rate_i` that differs from the previous block's value is a lock-style error when `cfg_var_rate_i`=0. It is ignored when `cfg_var_rate_i`=1.
- R9: Both values are captured on every block, whatever the flag state. The first block after reset is never flagged, and each later block is compared only with the one just before it.
- R10: With `cfg_npcm_err_i`=1, `npcm_i`=1 is a lock-style error that holds the flag and mutes the data. With `cfg_npcm_err_i`=0, `npcm_i` has no effect.
- R11: During and right after reset, `err_o` and `mute_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Receiver PLL locked |
| pre_miss_i | input | 1 | One-cycle strobe: an expected preamble was not found |
| sf_stb_i | input | 1 | One-cycle strobe at the end of each subframe |
| sf_odd_i | input | 1 | Parity bits of the subframe hold an odd number of ones |
| npcm_i | input | 1 | Incoming stream carries non-PCM data |
| blk_stb_i | input | 1 | One-cycle strobe at the end of each channel-status block |
| cs_fs_i | input | CS_W | Channel-status sampling-rate bits of the block |
| meas_rate_i | input | RATE_W | Measured sample-rate code |
| lrck_i | input | 1 | Left/right frame clock |
| cfg_var_rate_i | input | 1 | Variable-rate mode: ignore measured-rate changes |
| cfg_npcm_err_i | input | 1 | Treat non-PCM input as an error |
| cfg_soft_fmt_i | input | 1 | Show short parity-error runs as a one-frame flag |
| err_o | output | 1 | Error flag |
| mute_o | output | 1 | Mute control for the audio data |

## Verification
The bench builds the block with `HOLD_FRAMES`=6 and an 8-clock frame. A full hold and release then take about fifty clocks, so every scenario can run to release and restart within a short run. `PAR_LIMIT` stays at 9 and `RUN_W` at 4. A run of 8 parity errors and a run of 9 fall on either side of the limit. A run of 20 goes past the saturation value of 15, so a counter that wrapped would release the flag too early. The bench also repeats a block value, and sends a rate change in variable-rate mode, to show that the capture of the previous block is current.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FAULT = 2'd2,
        ST_HOLD  = 2'd3
    } hold_st_e;
endpackage

// File: rtl/rx_err_par_run.sv
module rx_err_par_run #(
    parameter int PAR_LIMIT = 9,
    parameter int RUN_W     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sf_stb_i,
    input  logic sf_odd_i,
    output logic par_err_o,
    output logic run_hard_o
);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;
    localparam logic [RUN_W-1:0] LIMIT   = RUN_W'(PAR_LIMIT);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (sf_stb_i) begin
            if (!sf_odd_i) begin
                run_q <= '0;
            end else if (run_q != RUN_MAX) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign par_err_o  = sf_stb_i & sf_odd_i;
    assign run_hard_o = (run_q >= LIMIT);

    // R4: a good subframe ends any run
    p_good_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_stb_i && !sf_odd_i) |=> !run_hard_o);
    // R5: the escalation starts only on a parity error
    p_hard_needs_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_hard_o) |-> $past(sf_stb_i && sf_odd_i));
endmodule

// File: rtl/rx_err_blk_cmp.sv
module rx_err_blk_cmp #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb_i,
    input  logic [W-1:0] val_i,
    output logic         diff_o
);
    logic [W-1:0] prev_q;
    logic         have_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            have_q <= 1'b0;
        end else if (stb_i) begin
            prev_q <= val_i;
            have_q <= 1'b1;
        end
    end

    assign diff_o = stb_i & have_q & (val_i != prev_q);

    // R9: every block is captured
    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i |=> (prev_q == $past(val_i)));
endmodule

// File: rtl/rx_err_hold_fsm.sv
module rx_err_hold_fsm
    import rx_err_pkg::*;
#(
    parameter int HOLD_FRAMES = 4800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cause_i,
    input  logic lrck_rise_i,
    output logic hard_o,
    output logic busy_o
);
    localparam int CNT_W = $clog2(HOLD_FRAMES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_FRAMES - 1);

    hold_st_e         state, nxt;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            state <= nxt;
            if (state != ST_HOLD) begin
                cnt_q <= '0;
            end else if (!cause_i && lrck_rise_i) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (cause_i) nxt = ST_ARMED;
            ST_ARMED: if (lrck_rise_i) nxt = ST_FAULT;
            ST_FAULT: if (!cause_i) nxt = ST_HOLD;
            ST_HOLD: begin
                if (cause_i) begin
                    nxt = ST_FAULT;
                end else if (lrck_rise_i && cnt_q == LAST) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign hard_o = (state == ST_FAULT) || (state == ST_HOLD);
    assign busy_o = (state != ST_IDLE);

    // R3: the hard flag moves only after a frame edge
    p_edge_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_o != $past(hard_o)) |-> $past(lrck_rise_i));
    // R2: no release while a cause is present
    p_release_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hard_o) |-> !$past(cause_i));
endmodule

// File: rtl/rx_err_flag.sv
module rx_err_flag #(
    parameter int HOLD_FRAMES = 4800,
    parameter int PAR_LIMIT   = 9,
    parameter int RUN_W       = 4,
    parameter int CS_W        = 4,
    parameter int RATE_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_i,
    input  logic              pre_miss_i,
    input  logic              sf_stb_i,
    input  logic              sf_odd_i,
    input  logic              npcm_i,
    input  logic              blk_stb_i,
    input  logic [CS_W-1:0]   cs_fs_i,
    input  logic [RATE_W-1:0] meas_rate_i,
    input  logic              lrck_i,
    input  logic              cfg_var_rate_i,
    input  logic              cfg_npcm_err_i,
    input  logic              cfg_soft_fmt_i,
    output logic              err_o,
    output logic              mute_o
);
    logic lrck_q, lrck_rise;
    logic par_err, run_hard;
    logic cs_diff, rate_diff;
    logic cause, hard, busy;
    logic soft_pend_q, soft_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lrck_q      <= 1'b0;
            soft_pend_q <= 1'b0;
            soft_q      <= 1'b0;
        end else begin
            lrck_q <= lrck_i;
            if (lrck_rise) begin
                soft_q      <= cfg_soft_fmt_i & (soft_pend_q | par_err);
                soft_pend_q <= 1'b0;
            end else begin
                soft_pend_q <= soft_pend_q | par_err;
            end
        end
    end

    assign lrck_rise = lrck_i & ~lrck_q;

    rx_err_par_run #(.PAR_LIMIT(PAR_LIMIT), .RUN_W(RUN_W)) u_run (
        .clk(clk), .rst_n(rst_n), .sf_stb_i(sf_stb_i), .sf_odd_i(sf_odd_i),
        .par_err_o(par_err), .run_hard_o(run_hard)
    );

    rx_err_blk_cmp #(.W(CS_W)) u_cs_cmp (
        .clk(clk), .rst_n(rst_n), .stb_i(blk_stb_i), .val_i(cs_fs_i), .diff_o(cs_diff)
    );

    rx_err_blk_cmp #(.W(RATE_W)) u_rate_cmp (
        .clk(clk), .rst_n(rst_n), .stb_i(blk_stb_i), .val_i(meas_rate_i), .diff_o(rate_diff)
    );

    assign cause = ~lock_i | pre_miss_i | run_hard | cs_diff
                 | (rate_diff & ~cfg_var_rate_i)
                 | (npcm_i & cfg_npcm_err_i);

    rx_err_hold_fsm #(.HOLD_FRAMES(HOLD_FRAMES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cause_i(cause), .lrck_rise_i(lrck_rise),
        .hard_o(hard), .busy_o(busy)
    );

    assign err_o  = hard | soft_q;
    assign mute_o = hard;

    // R1: loss of lock always leaves the idle state
    p_lockloss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_i |=> busy);
    // R7: a changed rate field of the channel status is a lock-style error
    p_cs_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_diff |=> busy);
    // R10: non-PCM input is an error when enabled
    p_npcm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (npcm_i && cfg_npcm_err_i) |=> busy);
endmodule

// File: tb/rx_err_flag_tb.sv
module rx_err_flag_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock = 1'b1, pre_miss = 1'b0, sf_stb = 1'b0, sf_odd = 1'b0, npcm = 1'b0;
    logic blk_stb = 1'b0, lrck = 1'b0;
    logic [3:0] cs_v = 4'h0, rate_v = 4'h0;
    logic cfg_var = 1'b0, cfg_npcm = 1'b0, cfg_fmt = 1'b0;
    logic err, mute;

    int n_tests = 0, n_fail = 0;
    int lr_cnt = 0, par_left = 0;
    logic prev_err = 1'b0, seen_err = 1'b0, seen_mute = 1'b0;
    string cur_req = "R11";

    // behavioural reference state
    bit m_high, m_armed, m_have, m_soft, m_pend, m_lr, m_rise_seen;
    int m_quiet, m_run;
    logic [3:0] m_cs, m_rt;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_err_flag #(.HOLD_FRAMES(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .lock_i(lock), .pre_miss_i(pre_miss),
        .sf_stb_i(sf_stb), .sf_odd_i(sf_odd), .npcm_i(npcm), .blk_stb_i(blk_stb),
        .cs_fs_i(cs_v), .meas_rate_i(rate_v), .lrck_i(lrck),
        .cfg_var_rate_i(cfg_var), .cfg_npcm_err_i(cfg_npcm), .cfg_soft_fmt_i(cfg_fmt),
        .err_o(err), .mute_o(mute)
    );

    always @(posedge clk or negedge rst_n) begin
        bit rise, dcs, drt, cause, perr;
        if (!rst_n) begin
            m_high = 0; m_armed = 0; m_have = 0; m_soft = 0; m_pend = 0;
            m_lr = 0; m_rise_seen = 0; m_quiet = 0; m_run = 0; m_cs = 0; m_rt = 0;
        end else begin
            rise = lrck && !m_lr;
            m_lr = lrck;
            dcs = blk_stb && m_have && (cs_v != m_cs);
            drt = blk_stb && m_have && (rate_v != m_rt);
            cause = !lock || pre_miss || (m_run >= 9) || dcs || (drt && !cfg_var)
                    || (npcm && cfg_npcm);
            perr = sf_stb && sf_odd;
            if (sf_stb) m_run = sf_odd ? ((m_run < 15) ? m_run + 1 : 15) : 0;
            if (blk_stb) begin m_cs = cs_v; m_rt = rate_v; m_have = 1; end
            if (!m_high) begin
                if (m_armed) begin
                    if (rise) begin m_high = 1; m_armed = 0; m_quiet = -1; end
                end else if (cause) m_armed = 1;
            end else if (m_quiet < 0) begin
                if (!cause) m_quiet = 0;
            end else if (cause) begin
                m_quiet = -1;
            end else if (rise) begin
                if (m_quiet == HOLD - 1) m_high = 0;
                else m_quiet++;
            end
            if (rise) begin m_soft = cfg_fmt && (m_pend || perr); m_pend = 0; end
            else m_pend = m_pend || perr;
            m_rise_seen = rise;
        end
    end

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            n_tests++;
            if (err !== (m_high || m_soft) || mute !== m_high) begin
                n_fail++;
                $display("FAIL %s cycle model: err=%b mute=%b expected err=%b mute=%b",
                         cur_req, err, mute, m_high || m_soft, m_high);
            end
            if (err !== prev_err) begin
                n_tests++;
                if (!m_rise_seen) begin
                    n_fail++;
                    $display("FAIL R3 flag moved off frame edge: err=%b expected %b", err, prev_err);
                end
            end
            prev_err = err;
            seen_err = seen_err | err;
            seen_mute = seen_mute | mute;
            pre_miss = 1'b0;
            blk_stb = 1'b0;
            lr_cnt++;
            lrck = lr_cnt[2];
            sf_stb = (lr_cnt[1:0] == 2'b00);
            sf_odd = sf_stb && (par_left > 0);
            if (sf_odd) par_left--;
        end
    endtask

    task automatic expect_bit(string tag, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic send_blk(logic [3:0] c, logic [3:0] r);
        cs_v = c; rate_v = r; blk_stb = 1'b1;
        run(1);
    endtask

    task automatic clear_seen();
        seen_err = 1'b0; seen_mute = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        expect_bit("R11 err in reset", err, 1'b0);
        expect_bit("R11 mute in reset", mute, 1'b0);
        rst_n = 1'b1;
        run(2);
        expect_bit("R11 err after reset", err, 1'b0);

        cur_req = "R9";
        send_blk(4'h2, 4'h3);
        run(20);
        expect_bit("R9 first block not flagged", err, 1'b0);

        cur_req = "R1";
        lock = 1'b0;
        run(12);
        expect_bit("R1 lock loss err", err, 1'b1);
        expect_bit("R1 lock loss mute", mute, 1'b1);
        cur_req = "R2";
        lock = 1'b1;
        run(24);
        expect_bit("R2 still held", err, 1'b1);
        run(60);
        expect_bit("R2 released", err, 1'b0);

        cur_req = "R1";
        pre_miss = 1'b1;
        run(12);
        expect_bit("R1 preamble miss", err, 1'b1);
        run(80);
        expect_bit("R2 release after preamble", err, 1'b0);

        cur_req = "R5";
        clear_seen();
        par_left = 8;
        run(48);
        expect_bit("R5 eight errors no flag", seen_err, 1'b0);
        par_left = 9;
        run(48);
        expect_bit("R5 nine errors err", err, 1'b1);
        expect_bit("R5 nine errors mute", mute, 1'b1);
        run(80);
        expect_bit("R5 release", err, 1'b0);

        cur_req = "R4";
        par_left = 20;
        run(76);
        expect_bit("R4 saturating run holds flag", err, 1'b1);
        run(100);
        expect_bit("R4 release after good subframe", err, 1'b0);

        cur_req = "R6";
        cfg_fmt = 1'b1;
        clear_seen();
        par_left = 1;
        run(30);
        expect_bit("R6 soft flag shown", seen_err, 1'b1);
        expect_bit("R6 soft flag no mute", seen_mute, 1'b0);
        cfg_fmt = 1'b0;
        clear_seen();
        par_left = 1;
        run(30);
        expect_bit("R6 soft flag hidden", seen_err, 1'b0);

        cur_req = "R7";
        send_blk(4'h5, 4'h3);
        run(12);
        expect_bit("R7 cs change", err, 1'b1);
        run(80);
        expect_bit("R7 release", err, 1'b0);
        cur_req = "R9";
        clear_seen();
        send_blk(4'h5, 4'h3);
        run(30);
        expect_bit("R9 repeated block no flag", seen_err, 1'b0);

        cur_req = "R8";
        send_blk(4'h5, 4'h6);
        run(12);
        expect_bit("R8 rate change", err, 1'b1);
        run(80);
        cfg_var = 1'b1;
        clear_seen();
        send_blk(4'h5, 4'h1);
        run(30);
        expect_bit("R8 variable rate ignored", seen_err, 1'b0);
        cfg_var = 1'b0;
        cur_req = "R9";
        clear_seen();
        send_blk(4'h5, 4'h1);
        run(30);
        expect_bit("R9 rate captured in variable mode", seen_err, 1'b0);

        cur_req = "R10";
        clear_seen();
        npcm = 1'b1;
        run(30);
        expect_bit("R10 non-PCM ignored when disabled", seen_err, 1'b0);
        cfg_npcm = 1'b1;
        run(12);
        expect_bit("R10 non-PCM err", err, 1'b1);
        expect_bit("R10 non-PCM mute", mute, 1'b1);
        npcm = 1'b0;
        run(80);
        expect_bit("R10 release", err, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule